// File: doc/BRIEF.md
# MSI-X Vector Table and Interrupt Message Generator

This block holds a per-function MSI-X vector table and its pending-bit array behind a simple word-addressed register port, and turns vector events from user logic into single-dword memory-write requests on a transmit request interface. Host software programs each vector's target address, message data and mask through the register port. User logic pulses one event line per vector. The block sends the message at once when delivery is allowed. When delivery is blocked it keeps a pending bit and releases the message as soon as delivery becomes allowed.

Delivery is allowed only when two things hold. The function-level enable from the configuration control bus must be high and the function-level mask must be low. The vector's own mask bit must also be clear. Each eligible vector produces exactly one memory-write request. The request carries the programmed 64-bit address, a length of one dword, a first byte enable of all ones, a last byte enable of zero and the 32-bit message data. A flag selects the 4-DW header form whenever the upper address word is nonzero. When several vectors wait at once, the lowest-numbered vector goes first. Only one request is in flight at a time, and a valid/ready handshake governs it.

Top module: `msix_irq_engine`

## Requirements
- R1: Table entry i occupies bytes 16*i to 16*i+15 of the register space. Dword slot 0 is the address low word, slot 1 the address high word, slot 2 the message data and slot 3 the control word, where bit 0 is the vector mask and bits 31:1 read as zero. Reads return data combinationally in the same cycle. Writes with byte address bits 1:0 nonzero are ignored.
- R2: After reset every entry's control word reads 1 (masked), its address and data read 0, all pending bits are 0 and tx_valid is low.
- R3: The pending array starts at byte NUM_VEC*16. Bit b of pending dword j belongs to vector 32*j+b. The array is read-only: writes to it have no effect.
- R4: An event pulse sampled at a clock edge sets that vector's pending bit. If the vector is eligible and the transmit slot is free, tx_valid is high after the second edge counted from that sample.
- R5: Every request has tx_len = 1, tx_first_be = 4'b1111 and tx_last_be = 4'b0000. Its tx_addr is {address high, address low}, its tx_data is the message data, and tx_4dw is 1 exactly when the address high word is nonzero.
- R6: While cfg_msix_en is 0 or cfg_func_mask is 1, no request is issued. Events still set pending bits, and these are delivered once the enable is 1 and the mask is 0.
- R7: An event on a vector whose mask bit is 1 only sets its pending bit. Clearing the mask releases the request. The pending bit clears when the request is launched.
- R8: When several vectors are eligible, they are sent one at a time in ascending vector order.
- R9: While tx_valid is high and tx_ready is low, tx_valid and all header and payload outputs hold. A new request may launch on the same edge that accepts the previous one.
- R10: Repeated events on a vector that is already pending result in a single request.
- R11: Table writes made after a request has launched do not alter that request's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| vec_event | input | NUM_VEC | One-cycle event pulse per vector |
| cfg_msix_en | input | 1 | Function-level MSI-X enable from config control bus |
| cfg_func_mask | input | 1 | Function-level mask from config control bus |
| tx_valid | output | 1 | Request valid |
| tx_ready | input | 1 | Request accepted when high with tx_valid |
| tx_addr | output | 64 | Memory-write target address |
| tx_data | output | 32 | Single-dword payload |
| tx_4dw | output | 1 | 1 = 4-DW header, 0 = 3-DW header |
| tx_len | output | 10 | Payload length in dwords |
| tx_first_be | output | 4 | First dword byte enables |
| tx_last_be | output | 4 | Last dword byte enables |

## Verification
The bench builds the block with its default of eight vectors. With that setting the pending array fits in one dword at byte 0x80, and the register address is eight bits wide. At this size a single event pulse can raise several vectors at once, so the ascending-order rule is exercised across the full vector range. Two entries are given nonzero upper addresses, which brings both header forms into the same request stream. Deliberately stalled ready periods, combined with table writes during the stall, expose the hold and capture behaviour.

// File: rtl/msix_pkg.sv
package msix_pkg;

  typedef enum logic [1:0] {
    SLOT_ADDR_LO = 2'd0,
    SLOT_ADDR_HI = 2'd1,
    SLOT_DATA    = 2'd2,
    SLOT_CTRL    = 2'd3
  } slot_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic        wide_hdr;
  } msix_msg_t;

  // A 4-DW header is needed whenever the upper address word is in use.
  function automatic logic need_4dw(input logic [63:0] a);
    return |a[63:32];
  endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VEC_W-1:0]   wr_idx,
  input  slot_e              wr_slot,
  input  logic [31:0]        wr_data,
  input  logic [VEC_W-1:0]   rd_idx,
  input  slot_e              rd_slot,
  output logic [31:0]        rd_data,
  input  logic [VEC_W-1:0]   sel_idx,
  output msix_msg_t          sel_msg,
  output logic [NUM_VEC-1:0] mask_vec
);

  logic [31:0]        lo_q  [NUM_VEC];
  logic [31:0]        hi_q  [NUM_VEC];
  logic [31:0]        dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
      end
      mask_q <= '1;
    end else if (wr_en) begin
      case (wr_slot)
        SLOT_ADDR_LO: lo_q[wr_idx]   <= wr_data;
        SLOT_ADDR_HI: hi_q[wr_idx]   <= wr_data;
        SLOT_DATA:    dat_q[wr_idx]  <= wr_data;
        SLOT_CTRL:    mask_q[wr_idx] <= wr_data[0];
        default:      ;
      endcase
    end
  end

  always_comb begin
    case (rd_slot)
      SLOT_ADDR_LO: rd_data = lo_q[rd_idx];
      SLOT_ADDR_HI: rd_data = hi_q[rd_idx];
      SLOT_DATA:    rd_data = dat_q[rd_idx];
      default:      rd_data = {31'd0, mask_q[rd_idx]};
    endcase
  end

  always_comb begin
    sel_msg.addr     = {hi_q[sel_idx], lo_q[sel_idx]};
    sel_msg.data     = dat_q[sel_idx];
    sel_msg.wide_hdr = need_4dw({hi_q[sel_idx], lo_q[sel_idx]});
  end

  assign mask_vec = mask_q;

endmodule

// File: rtl/msix_pend_array.sv
module msix_pend_array #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] evt,
  input  logic [NUM_VEC-1:0] clr_oh,
  output logic [NUM_VEC-1:0] pend
);

  logic [NUM_VEC-1:0] pend_q;

  // A fresh event wins over a launch-clear on the same vector.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_oh) | evt;
  end

  assign pend = pend_q;

  // R4: every event is visible in the pending array one edge later.
  assert_evt_recorded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));

  // R7: only a pending vector can be launched.
  assert_clear_only_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_oh) |-> ((clr_oh & ~pend) == '0));

  // R7: a launched vector leaves the array unless re-raised that cycle.
  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_oh) |=> (($past(clr_oh) & ~$past(evt) & pend) == '0));

endmodule

// File: rtl/msix_arbiter.sv
module msix_arbiter #(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] pend,
  input  logic [NUM_VEC-1:0] mask_vec,
  input  logic               gate_open,
  input  logic               slot_free,
  output logic [NUM_VEC-1:0] grant_oh,
  output logic [VEC_W-1:0]   grant_idx,
  output logic               grant
);

  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

  function automatic logic [NUM_VEC-1:0] lowest_set(input logic [NUM_VEC-1:0] x);
    return x & (~x + ONE);
  endfunction

  function automatic logic [VEC_W-1:0] oh_to_idx(input logic [NUM_VEC-1:0] oh);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (oh[i]) r = VEC_W'(i);
    return r;
  endfunction

  logic [NUM_VEC-1:0] eligible;

  assign eligible  = pend & ~mask_vec & {NUM_VEC{gate_open}};
  assign grant_oh  = slot_free ? lowest_set(eligible) : '0;
  assign grant_idx = oh_to_idx(grant_oh);
  assign grant     = |grant_oh;

  // R8: no lower-numbered unmasked pending vector is passed over.
  assert_lowest_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (((pend & ~mask_vec) & (grant_oh - ONE)) == '0));

  // R7: a masked vector is never granted.
  assert_no_masked_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ((grant_oh & mask_vec) == '0));

endmodule

// File: rtl/msix_tx_stage.sv
module msix_tx_stage
  import msix_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  msix_msg_t load_msg,
  input  logic      tx_ready,
  output logic      tx_valid,
  output msix_msg_t msg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      msg_q    <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      msg_q    <= load_msg;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // R9: a stalled request holds every field.
  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(msg_q)));

  // R8: one request in flight; a load only into a free or draining slot.
  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!tx_valid || tx_ready));

endmodule

// File: rtl/msix_irq_engine.sv
module msix_irq_engine
  import msix_pkg::*;
#(
  parameter  int NUM_VEC = 8,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int REG_AW  = VEC_W + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] vec_event,
  input  logic               cfg_msix_en,
  input  logic               cfg_func_mask,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [63:0]        tx_addr,
  output logic [31:0]        tx_data,
  output logic               tx_4dw,
  output logic [9:0]         tx_len,
  output logic [3:0]         tx_first_be,
  output logic [3:0]         tx_last_be
);

  localparam int PBA_DW = (NUM_VEC + 31) / 32;

  // Address decode: top bit picks the pending array, the rest index the table.
  logic               in_pba;
  logic [VEC_W-1:0]   tbl_idx;
  slot_e              tbl_slot;
  logic [VEC_W+2:0]   pba_word;
  logic               tbl_wr;

  assign in_pba   = reg_addr[REG_AW-1];
  assign tbl_idx  = reg_addr[REG_AW-2:4];
  assign tbl_slot = slot_e'(reg_addr[3:2]);
  assign pba_word = reg_addr[REG_AW-2:2];
  assign tbl_wr   = reg_we && !in_pba && (reg_addr[1:0] == 2'b00);

  // Internal events brought out for the assertions.
  logic [NUM_VEC-1:0] mask_vec;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] grant_oh;
  logic [VEC_W-1:0]   grant_idx;
  logic               grant;
  logic               gate_open;
  logic               slot_free;
  logic [31:0]        tbl_rdata;
  msix_msg_t          sel_msg;
  msix_msg_t          out_msg;

  assign gate_open = cfg_msix_en && !cfg_func_mask;
  assign slot_free = !tx_valid || tx_ready;

  msix_vec_table #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr),
    .wr_idx   (tbl_idx),
    .wr_slot  (tbl_slot),
    .wr_data  (reg_wdata),
    .rd_idx   (tbl_idx),
    .rd_slot  (tbl_slot),
    .rd_data  (tbl_rdata),
    .sel_idx  (grant_idx),
    .sel_msg  (sel_msg),
    .mask_vec (mask_vec)
  );

  msix_pend_array #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (vec_event),
    .clr_oh (grant_oh),
    .pend   (pend)
  );

  msix_arbiter #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .mask_vec  (mask_vec),
    .gate_open (gate_open),
    .slot_free (slot_free),
    .grant_oh  (grant_oh),
    .grant_idx (grant_idx),
    .grant     (grant)
  );

  msix_tx_stage u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (grant),
    .load_msg (sel_msg),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .msg_q    (out_msg)
  );

  // Read mux: pending dwords are zero-padded past the last vector.
  logic [PBA_DW*32-1:0] pend_pad;
  assign pend_pad = (PBA_DW*32)'(pend);

  always_comb begin
    reg_rdata = tbl_rdata;
    if (in_pba) begin
      reg_rdata = '0;
      for (int j = 0; j < PBA_DW; j++)
        if (int'(pba_word) == j) reg_rdata = pend_pad[j*32 +: 32];
    end
  end

  assign tx_addr     = out_msg.addr;
  assign tx_data     = out_msg.data;
  assign tx_4dw      = out_msg.wide_hdr;
  assign tx_len      = 10'd1;
  assign tx_first_be = 4'b1111;
  assign tx_last_be  = 4'b0000;

  // R6: a launch happens only while the function gate is open.
  assert_gate_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (cfg_msix_en && !cfg_func_mask));

  // R5: header form agrees with the address carried.
  assert_hdr_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_4dw == (tx_addr[63:32] != 32'd0)));

  // R3: the pending array cannot be changed by a register write.
  assert_pba_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_pba && vec_event == '0 && !grant) |=> $stable(pend));

endmodule

// File: tb/msix_irq_engine_tb.sv
module msix_irq_engine_tb;

  localparam int NV = 8;
  localparam int AW = 8;
  localparam logic [7:0] PBA = 8'h80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NV-1:0] vec_event = '0;
  logic          cfg_msix_en = 1'b0;
  logic          cfg_func_mask = 1'b0;
  logic          tx_valid;
  logic          tx_ready = 1'b1;
  logic [63:0]   tx_addr;
  logic [31:0]   tx_data;
  logic          tx_4dw;
  logic [9:0]    tx_len;
  logic [3:0]    tx_first_be;
  logic [3:0]    tx_last_be;

  always #10 clk = ~clk;

  msix_irq_engine #(.NUM_VEC(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_event(vec_event),
    .cfg_msix_en(cfg_msix_en), .cfg_func_mask(cfg_func_mask),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr),
    .tx_data(tx_data), .tx_4dw(tx_4dw), .tx_len(tx_len),
    .tx_first_be(tx_first_be), .tx_last_be(tx_last_be)
  );

  typedef struct { logic [63:0] a; logic [31:0] d; logic w; } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;
  int rx_cnt = 0;
  bit done   = 0;

  logic [31:0] m_lo [NV];
  logic [31:0] m_hi [NV];
  logic [31:0] m_dat[NV];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    reg_addr = a; #1;
    chk(reg_rdata == e, tag, 64'(reg_rdata), 64'(e));
  endtask

  task automatic pulse(input logic [NV-1:0] v);
    vec_event = v;
    tick();
    vec_event = '0;
  endtask

  task automatic push(input int i);
    exp_t e;
    e.a = {m_hi[i], m_lo[i]};
    e.d = m_dat[i];
    e.w = (m_hi[i] != 32'd0);
    q.push_back(e);
  endtask

  task automatic settle();
    repeat (10) tick();
  endtask

  // Scoreboard monitor: compare each accepted request with the queue head.
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      rx_cnt++;
      if (q.size() == 0) begin
        chk(1'b0, "R6/R7 unexpected request", tx_addr, 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(tx_addr == e.a, "R5 address", tx_addr, e.a);
        chk(tx_data == e.d, "R5 data", 64'(tx_data), 64'(e.d));
        chk(tx_4dw == e.w, "R5 header form", 64'(tx_4dw), 64'(e.w));
        chk(tx_len == 10'd1 && tx_first_be == 4'hF && tx_last_be == 4'h0,
            "R5 length/byte enables", {50'd0, tx_len, tx_first_be}, {50'd0, 10'd1, 4'hF});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [63:0] ha;
    logic [31:0] hd;
    for (int i = 0; i < NV; i++) begin
      m_lo[i]  = 32'h1000_0000 + 32'(i) * 32'h40;
      m_hi[i]  = (i == 3 || i == 5) ? 32'h0000_00A0 + 32'(i) : 32'd0;
      m_dat[i] = 32'hC0DE_0000 + 32'(i);
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R2: reset state
    chk(tx_valid == 1'b0, "R2 tx_valid after reset", 64'(tx_valid), 64'd0);
    rd_chk(8'h0C, 32'd1, "R2 entry0 control masked");
    rd_chk(8'h7C, 32'd1, "R2 entry7 control masked");
    rd_chk(8'h70, 32'd0, "R2 entry7 address low");
    rd_chk(8'h28, 32'd0, "R2 entry2 data");
    rd_chk(PBA, 32'd0, "R2 pending empty");

    // R1: program the table and read back
    for (int i = 0; i < NV; i++) begin
      wr(8'(i * 16 + 0), m_lo[i]);
      wr(8'(i * 16 + 4), m_hi[i]);
      wr(8'(i * 16 + 8), m_dat[i]);
    end
    rd_chk(8'h30, m_lo[3], "R1 entry3 address low");
    rd_chk(8'h34, m_hi[3], "R1 entry3 address high");
    rd_chk(8'h38, m_dat[3], "R1 entry3 data");
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk(8'h3C, 32'd1, "R1 control upper bits read zero");
    wr(8'h39, 32'h1234_5678);
    rd_chk(8'h38, m_dat[3], "R1 misaligned write ignored");

    // R3: pending array is read-only
    wr(PBA, 32'hFFFF_FFFF);
    rd_chk(PBA, 32'd0, "R3 pending write ignored");

    // R6: gate closed (enable low); unmask everything, events pend
    for (int i = 0; i < NV; i++) wr(8'(i * 16 + 12), 32'd0);
    c0 = rx_cnt;
    pulse(8'h24);
    settle();
    chk(rx_cnt == c0, "R6 no request while disabled", 64'(rx_cnt), 64'(c0));
    rd_chk(PBA, 32'h24, "R3 pending bits 2 and 5");
    push(2); push(5);
    cfg_msix_en = 1'b1;
    settle();
    chk(rx_cnt == c0 + 2, "R6 release on enable", 64'(rx_cnt), 64'(c0 + 2));
    rd_chk(PBA, 32'd0, "R7 pending cleared after launch");

    // R6: function mask
    cfg_func_mask = 1'b1;
    c0 = rx_cnt;
    pulse(8'h02);
    settle();
    chk(rx_cnt == c0, "R6 no request while function masked", 64'(rx_cnt), 64'(c0));
    rd_chk(PBA, 32'h02, "R6 pending under function mask");
    push(1);
    cfg_func_mask = 1'b0;
    settle();
    chk(rx_cnt == c0 + 1, "R6 release on function unmask", 64'(rx_cnt), 64'(c0 + 1));

    // R7: per-vector mask
    wr(8'h4C, 32'd1);
    c0 = rx_cnt;
    push(6);
    pulse(8'h50);
    settle();
    chk(rx_cnt == c0 + 1, "R7 only unmasked vector sent", 64'(rx_cnt), 64'(c0 + 1));
    rd_chk(PBA, 32'h10, "R7 masked vector pending");
    push(4);
    wr(8'h4C, 32'd0);
    settle();
    rd_chk(PBA, 32'd0, "R7 pending cleared on unmask");
    chk(rx_cnt == c0 + 2, "R7 release on vector unmask", 64'(rx_cnt), 64'(c0 + 2));

    // R8: ascending order
    cfg_msix_en = 1'b0;
    pulse(8'h89);
    settle();
    rd_chk(PBA, 32'h89, "R8 three vectors pending");
    push(0); push(3); push(7);
    cfg_msix_en = 1'b1;
    settle();
    chk(q.size() == 0, "R8 all ordered requests drained", 64'(q.size()), 64'd0);

    // R4: latency from event to tx_valid
    push(1);
    vec_event = 8'h02;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R4 valid low before sample edge", 64'(tx_valid), 64'd0);
    @(posedge clk); #1; vec_event = '0;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R4 valid low after first edge", 64'(tx_valid), 64'd0);
    @(negedge clk);
    chk(tx_valid == 1'b1, "R4 valid high after second edge", 64'(tx_valid), 64'd1);
    tick();
    settle();

    // R9 and R11: stall holds; table write after launch has no effect
    tx_ready = 1'b0;
    push(2);
    pulse(8'h04);
    repeat (3) tick();
    chk(tx_valid == 1'b1, "R9 valid raised under stall", 64'(tx_valid), 64'd1);
    ha = tx_addr; hd = tx_data;
    wr(8'h28, 32'hBEEF_0002);
    wr(8'h20, 32'h2222_0000);
    repeat (3) tick();
    chk(tx_valid == 1'b1 && tx_addr == ha, "R9 address held under stall", tx_addr, ha);
    chk(tx_data == hd, "R11 data unchanged by later write", 64'(tx_data), 64'(hd));
    m_dat[2] = 32'hBEEF_0002;
    m_lo[2]  = 32'h2222_0000;
    tx_ready = 1'b1;
    settle();

    // R9: back-to-back launches
    c0 = rx_cnt;
    push(1); push(2);
    pulse(8'h06);
    settle();
    chk(rx_cnt == c0 + 2, "R9 back-to-back requests", 64'(rx_cnt), 64'(c0 + 2));

    // R10: coalescing
    wr(8'h0C, 32'd1);
    c0 = rx_cnt;
    pulse(8'h01); pulse(8'h01); tick(); pulse(8'h01);
    rd_chk(PBA, 32'h01, "R10 single pending bit");
    push(0);
    wr(8'h0C, 32'd0);
    settle();
    chk(rx_cnt == c0 + 1, "R10 one request for repeated events", 64'(rx_cnt), 64'(c0 + 1));

    chk(q.size() == 0, "R8 scoreboard empty at end", 64'(q.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule